// File: doc/BRIEF.md
# DDR SDRAM Bank Activation Checker

This block watches the command lines of a four-bank DDR SDRAM and reports every command that breaks the bank activation rules. It samples chip select, row strobe, column strobe, write enable, the two bank-select bits and address bit 10 on each rising clock edge. It keeps one small state machine per bank. Each machine records whether the bank has an open row, and it runs a saturating count of the cycles since the last activate that was accepted for that bank.

Every activate is checked against three things: the bank must not already be open, the row cycle time since that bank's previous activate must have passed, and the bank-to-bank gap since any other bank's activate must have passed. Every read or write is checked for an open target bank and for the activate-to-column delay. A failed check produces a one-cycle pulse on the flag for that rule, together with the number of the offending bank. The three timing limits, and the number of cycles an auto-precharge takes to close a bank, are parameters counted in clock cycles. The block is meant to sit beside a memory controller in simulation or in silicon as a protocol monitor.

Top module: `ddr_act_monitor`

## Requirements
- R1: Commands are decoded at each rising edge. Activate is cs_n=0, ras_n=0, cas_n=1, we_n=1. Read is cs_n=0, ras_n=1, cas_n=0, we_n=1. Write is the same as read but with we_n=0. Precharge is cs_n=0, ras_n=0, cas_n=1, we_n=0. Any cycle with cs_n=1, and any other pattern, raises no flag and changes no state.
- R2: Four banks are tracked independently and selected by the two-bit `ba` sampled with the command.
- R3: A read or write to a bank with no open row raises `err_col_idle`.
- R4: A read or write to an open bank fewer than T_RCD cycles after that bank's activate raises `err_rcd`. At exactly T_RCD cycles the command is legal.
- R5: An activate to a bank that already has an open row raises `err_act_open`.
- R6: An activate issued fewer than T_RRD cycles after an accepted activate to any other bank raises `err_rrd`. At exactly T_RRD cycles it is legal.
- R7: An activate to an idle bank fewer than T_RC cycles after that bank's previous accepted activate raises `err_rc`. At exactly T_RC cycles it is legal.
- R8: A precharge closes the addressed bank when `a10`=0, and closes all four banks when `a10`=1.
- R9: An accepted read or write with `a10`=1 requests auto-precharge. The bank still counts as open for commands up to and including the AP_DELAY-th cycle after the column command. From the next cycle on it counts as idle.
- R10: A command that raises any flag changes no bank state. It does not open a bank, restart a counter or start an auto-precharge.
- R11: Flags are registered. Each one is high for exactly the cycle after the offending command's clock edge, and in that cycle `err_bank` holds that command's `ba`.
- R12: An active-low synchronous reset makes every bank idle and saturates every counter, so the first activate after reset is legal. All flags are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10: all-bank precharge or auto-precharge request |
| err_col_idle | output | 1 | Read or write to a bank with no open row |
| err_rcd | output | 1 | Read or write issued too soon after its bank's activate |
| err_act_open | output | 1 | Activate to a bank that is already open |
| err_rrd | output | 1 | Activate issued too soon after another bank's activate |
| err_rc | output | 1 | Activate issued too soon after the same bank's previous activate |
| err_bank | output | 2 | Bank number of the flagged command |

## Verification
The bench probes each spacing rule one cycle short of its limit and then exactly at it. An off-by-one counter would either flag the legal command or let the early one through. A rejected activate is followed by a command whose outcome depends on whether that activate took effect. A design that opened the bank or restarted the count on a violation would then report the wrong flag. Auto-precharge is checked on the last cycle the bank must still count as open and on the first cycle it must count as idle, which exposes a closing delay that is one cycle off. Precharge is tested for a single bank and for all banks, to catch a decoder that ignores `a10` or closes the wrong bank.

// File: rtl/ddr_mon_pkg.sv
// Package: shared command type and bank geometry for the activation checker.
// Assumes a four-bank device addressed by a two-bit bank select.
package ddr_mon_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BA_W      = 2;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } cmd_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
// ddr_cmd_decode: maps the four active-low control lines to a command code.
// Assumes the lines are stable around the sampling edge. Any pattern that
// is not activate, read, write or precharge (including deselect) is NOP.
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // Pure truth-table decode of the control lines.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_state.sv
// ddr_bank_state: open/idle state, cycles-since-activate counter and the
// auto-precharge countdown for one bank. Assumes the caller raises act_go
// only for legal activates and ap_go only for legal column commands.
module ddr_bank_state #(
    parameter int CNT_W    = 4,
    parameter int AP_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             ap_go,
    input  logic             pre_go,
    output logic             is_open,
    output logic [CNT_W-1:0] since_act
);
    localparam int AP_W = $clog2(AP_DELAY + 1);
    localparam logic [AP_W-1:0]  AP_LOAD = AP_W'(AP_DELAY);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic [AP_W-1:0] ap_left;

    // Track row state, saturating age counter and pending auto-precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open   <= 1'b0;
            since_act <= CNT_SAT;
            ap_left   <= '0;
        end else if (act_go) begin
            is_open   <= 1'b1;
            since_act <= CNT_W'(1);
            ap_left   <= '0;
        end else begin
            if (since_act != CNT_SAT) since_act <= since_act + 1'b1;
            if (pre_go) begin
                is_open <= 1'b0;
                ap_left <= '0;
            end else if (ap_go) begin
                ap_left <= AP_LOAD;
            end else if (ap_left != '0) begin
                ap_left <= ap_left - 1'b1;
                if (ap_left == AP_W'(1)) is_open <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ddr_viol_report.sv
// ddr_viol_report: registers the violation flags and the bank of the
// offending command, so every flag is a one-cycle pulse after its edge.
module ddr_viol_report #(
    parameter int BA_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      viol_in,
    input  logic [BA_W-1:0] bank_in,
    output logic [4:0]      viol_q,
    output logic [BA_W-1:0] bank_q
);
    // Capture the flags of this edge's command for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= '0;
            bank_q <= '0;
        end else begin
            viol_q <= viol_in;
            bank_q <= bank_in;
        end
    end
endmodule

// File: rtl/ddr_act_monitor.sv
// ddr_act_monitor: bank activation protocol checker for a four-bank DDR
// SDRAM. It decodes each command, judges it against per-bank state and
// spacing counters, and updates state only for commands that break no rule.
// Timing limits are in clock cycles and must each be at least 1.
module ddr_act_monitor
    import ddr_mon_pkg::*;
#(
    parameter int T_RCD    = 3,
    parameter int T_RRD    = 2,
    parameter int T_RC     = 10,
    parameter int AP_DELAY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    output logic       err_col_idle,
    output logic       err_rcd,
    output logic       err_act_open,
    output logic       err_rrd,
    output logic       err_rc,
    output logic [1:0] err_bank
);
    localparam int T_MAX1 = (T_RCD > T_RRD) ? T_RCD : T_RRD;
    localparam int T_MAX  = (T_MAX1 > T_RC) ? T_MAX1 : T_RC;
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] RCD_L = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] RRD_L = CNT_W'(T_RRD);
    localparam logic [CNT_W-1:0] RC_L  = CNT_W'(T_RC);

    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] open_v;
    logic [CNT_W-1:0]     age_v [NUM_BANKS];
    logic                 is_act, is_col, is_pre;
    logic                 v_idle, v_rcd, v_open, v_rrd, v_rc;
    logic                 act_ok, col_ok;
    logic [4:0]           viol_q;

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // Judge the current command against the addressed and the other banks.
    always_comb begin
        is_act = (cmd == CMD_ACT);
        is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
        is_pre = (cmd == CMD_PRE);
        v_idle = is_col && !open_v[ba];
        v_rcd  = is_col && open_v[ba] && (age_v[ba] < RCD_L);
        v_open = is_act && open_v[ba];
        v_rc   = is_act && !open_v[ba] && (age_v[ba] < RC_L);
        v_rrd  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (is_act && (BA_W'(b) != ba) && (age_v[b] < RRD_L)) v_rrd = 1'b1;
        end
        act_ok = is_act && !(v_open || v_rc || v_rrd);
        col_ok = is_col && !(v_idle || v_rcd);
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(g));
        ddr_bank_state #(
            .CNT_W    (CNT_W),
            .AP_DELAY (AP_DELAY)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (act_ok && sel),
            .ap_go     (col_ok && sel && a10),
            .pre_go    (is_pre && (a10 || sel)),
            .is_open   (open_v[g]),
            .since_act (age_v[g])
        );
    end

    ddr_viol_report #(.BA_W(BA_W)) u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .viol_in ({v_idle, v_rcd, v_open, v_rrd, v_rc}),
        .bank_in (ba),
        .viol_q  (viol_q),
        .bank_q  (err_bank)
    );

    assign {err_col_idle, err_rcd, err_act_open, err_rrd, err_rc} = viol_q;
endmodule

// File: rtl/ddr_act_monitor_chk.sv
// ddr_act_monitor_chk: port-level properties of the activation checker,
// bound into every instance of the top module.
module ddr_act_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [1:0] ba,
    input logic       err_col_idle,
    input logic       err_rcd,
    input logic       err_act_open,
    input logic       err_rrd,
    input logic       err_rc,
    input logic [1:0] err_bank
);
    logic any_flag;
    assign any_flag = err_col_idle | err_rcd | err_act_open | err_rrd | err_rc;

    AST_ACT_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_act_open || err_rrd || err_rc) |-> $past(!cs_n && !ras_n && cas_n && we_n)); // R1
    AST_COL_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_col_idle || err_rcd) |-> $past(!cs_n && ras_n && !cas_n)); // R3
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !any_flag); // R1
    AST_FLAG_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        any_flag |-> (err_bank == $past(ba))); // R11
    AST_COL_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_col_idle, err_rcd})); // R4
    AST_OPEN_OR_RC: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_act_open && err_rc)); // R7
endmodule

bind ddr_act_monitor ddr_act_monitor_chk u_chk (.*);

// File: tb/sim_ddr_act_monitor.sv
`timescale 1ns/1ps
module sim_ddr_act_monitor;
    localparam logic [4:0] F_NONE = 5'b00000;
    localparam logic [4:0] F_IDLE = 5'b10000;
    localparam logic [4:0] F_RCD  = 5'b01000;
    localparam logic [4:0] F_OPEN = 5'b00100;
    localparam logic [4:0] F_RRD  = 5'b00010;
    localparam logic [4:0] F_RC   = 5'b00001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic err_col_idle, err_rcd, err_act_open, err_rrd, err_rc;
    logic [1:0] err_bank;

    int n_vec = 0, n_bad = 0;
    logic [6:0] exp_q [$];
    string      tag_q [$];
    logic [6:0] e_item;
    string      e_tag;
    logic [4:0] got;

    always #2 clk = ~clk;

    ddr_act_monitor #(.T_RCD(3), .T_RRD(2), .T_RC(10), .AP_DELAY(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .err_col_idle(err_col_idle),
        .err_rcd(err_rcd), .err_act_open(err_act_open), .err_rrd(err_rrd),
        .err_rc(err_rc), .err_bank(err_bank)
    );

    // Driver: put one command on the bus and queue its expected flags.
    task automatic drive(input logic c, r, ca, w, input logic [1:0] b,
                         input logic a, input logic [4:0] ef, input string t);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
        exp_q.push_back({ef, b});
        tag_q.push_back(t);
    endtask
    task automatic act(input logic [1:0] b, input logic [4:0] ef, input string t);
        drive(1'b0, 1'b0, 1'b1, 1'b1, b, 1'b0, ef, t);
    endtask
    task automatic rd(input logic [1:0] b, input logic a, input logic [4:0] ef, input string t);
        drive(1'b0, 1'b1, 1'b0, 1'b1, b, a, ef, t);
    endtask
    task automatic wr(input logic [1:0] b, input logic a, input logic [4:0] ef, input string t);
        drive(1'b0, 1'b1, 1'b0, 1'b0, b, a, ef, t);
    endtask
    task automatic pre(input logic [1:0] b, input logic a, input string t);
        drive(1'b0, 1'b0, 1'b1, 1'b0, b, a, F_NONE, t);
    endtask
    task automatic nop(input int n, input string t);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, F_NONE, t);
    endtask

    // Monitor: after each edge, compare the registered flags with the queue.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            e_item = exp_q.pop_front();
            e_tag  = tag_q.pop_front();
            got    = {err_col_idle, err_rcd, err_act_open, err_rrd, err_rc};
            n_vec++;
            if (got != e_item[6:2] || (e_item[6:2] != 5'b0 && err_bank != e_item[1:0])) begin
                n_bad++;
                $display("FAIL %s: flags=%b bank=%0d expected flags=%b bank=%0d",
                         e_tag, got, err_bank, e_item[6:2], e_item[1:0]);
            end
        end
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if ({err_col_idle, err_rcd, err_act_open, err_rrd, err_rc} != 5'b0) begin
            n_bad++;
            $display("FAIL R12 reset flags: got %b expected 00000",
                     {err_col_idle, err_rcd, err_act_open, err_rrd, err_rc});
        end
        rst_n = 1'b1;

        rd(2'd0, 1'b0, F_IDLE, "R3 read to idle bank0");
        nop(1, "R11 flag is a single pulse");
        act(2'd0, F_NONE, "R12 first activate after reset");
        rd(2'd0, 1'b0, F_RCD, "R4 read one cycle after activate");
        wr(2'd0, 1'b0, F_RCD, "R4 write two cycles after activate");
        rd(2'd0, 1'b0, F_NONE, "R4 read at exactly T_RCD");
        act(2'd1, F_NONE, "R2 activate bank1");
        act(2'd2, F_RRD, "R6 bank2 one cycle after bank1");
        act(2'd2, F_NONE, "R6 bank2 at exactly T_RRD");
        nop(1, "R11 idle gap");
        act(2'd1, F_OPEN, "R5 activate to open bank1");
        pre(2'd0, 1'b0, "R8 precharge bank0 only");
        rd(2'd0, 1'b0, F_IDLE, "R8 bank0 closed by single precharge");
        rd(2'd1, 1'b0, F_NONE, "R8 bank1 left open by single precharge");
        pre(2'd3, 1'b1, "R8 precharge all banks");
        rd(2'd1, 1'b0, F_IDLE, "R8 bank1 closed by all-bank precharge");
        wr(2'd2, 1'b0, F_IDLE, "R8 bank2 closed by all-bank precharge");
        nop(10, "R2 quiet");
        act(2'd3, F_NONE, "R2 activate bank3");
        pre(2'd3, 1'b0, "R8 precharge bank3");
        act(2'd3, F_RC, "R7 reactivate bank3 before T_RC");
        nop(7, "R7 wait");
        act(2'd3, F_NONE, "R7 R10 reactivate bank3 at exactly T_RC");
        act(2'd0, F_RRD, "R6 bank0 right after bank3");
        wr(2'd0, 1'b0, F_IDLE, "R10 rejected activate left bank0 idle");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, F_NONE, "R1 deselected cycle ignored");
        drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, F_NONE, "R1 selected nop ignored");
        nop(2, "R1 quiet");
        act(2'd0, F_NONE, "R9 activate bank0");
        nop(2, "R9 wait T_RCD");
        wr(2'd0, 1'b1, F_NONE, "R9 write with auto-precharge");
        act(2'd0, F_OPEN, "R9 bank0 still open during auto-precharge");
        nop(2, "R9 wait");
        rd(2'd0, 1'b0, F_NONE, "R9 last cycle bank0 counts as open");
        rd(2'd0, 1'b0, F_IDLE, "R9 first cycle bank0 counts as idle");
        nop(2, "R11 drain");
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule